// File: doc/BRIEF.md
# Cascaded Fixed-Priority DMA Request Scheduler

This block decides which of ten DMA channels may run the next transfer. A channel asks for service through a software trigger pulse, through its own peripheral request line, or through a hard-wired cascade from another channel. A request is latched into a per-channel pending bit and held there. When no transfer is outstanding, the lowest-numbered pending channel wins. The block then issues a one-cycle grant and stays busy until the transfer engine reports a done pulse. Each grant covers a single transfer, so the bus is handed back after every item.

A done pulse can also carry an underflow flag, which means that the channel's transfer count wrapped. In that case the block sets a sticky per-channel bit in a grouped interrupt status vector. The interrupt output is the OR of the status bits that are enabled in a mask.

Cascade links are fixed in the wiring. After every single transfer: 0→1, 1→2, 2→0, 3→4, 5→6, 6→7, 7→5 and 8→9. After a count underflow, in addition: 0→5 and 3→8. Each target channel has its own cascade-enable bit. The address and data path, the count registers and the register decoding sit outside this block.

Top module: `dma_req_sched`

## Requirements
- R1: During and after reset, `grant_valid`, `busy`, `irq_status` and `irq` are all 0 and no channel is pending.
- R2: A software or peripheral pulse on an enabled channel, sampled at clock edge E while the block is idle, produces `grant_valid`=1 for exactly one cycle after edge E+1, with `grant_ch` equal to the binary channel number.
- R3: When several channels are pending, the grant goes to the lowest channel index (channel 0 is highest priority, channel 9 is lowest).
- R4: `busy` rises with the grant and falls at the edge that samples `done`. No grant is issued while `busy` is 1. A channel still pending is granted at the edge after the done edge.
- R5: A channel whose `ch_enable` bit is 0 latches no request, and its pending bit is dropped. Re-enabling the channel does not revive the dropped request.
- R6: A pending bit stays set until its channel is granted. A trigger for that channel sampled at the grant edge sets the bit again, so the channel is granted again after the following done.
- R7: A done pulse from the active channel sets the pending bit of its per-transfer successor (0→1, 1→2, 2→0, 3→4, 5→6, 6→7, 7→5, 8→9) only when the successor's `casc_enable` bit is 1. Channels 4 and 9 have no successor.
- R8: A done pulse with `done_uf`=1 on channel 0 also requests channel 5, and the same pulse on channel 3 also requests channel 8, each gated by the target's `casc_enable` bit.
- R9: A done pulse with `done_uf`=1 sets `irq_status[ch]` for the active channel. The bit stays set until a 1 is written to the matching `irq_clr` bit. A set and a clear in the same cycle leave the bit set.
- R10: `irq` is 1 exactly when some bit of `irq_status & irq_mask` is 1.
- R11: A `done` pulse while `busy` is 0 changes neither the grant state nor `irq_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 10 | Per-channel enable |
| casc_enable | input | 10 | Per-target cascade enable |
| sw_trig | input | 10 | Software trigger pulses, one bit per channel |
| periph_req | input | 10 | Peripheral request pulses, one bit per channel |
| done | input | 1 | Outstanding transfer finished |
| done_uf | input | 1 | The finished transfer made its count underflow |
| irq_mask | input | 10 | Interrupt enable per status bit |
| irq_clr | input | 10 | Write-1-to-clear for status bits |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_ch | output | 4 | Granted channel number |
| busy | output | 1 | A transfer is outstanding |
| irq_status | output | 10 | Sticky underflow bits |
| irq | output | 1 | Grouped interrupt |

## Verification
A trigger sampled at one edge shows up as a grant after the next edge, so the bench drives inputs at the falling edge and checks the grant two rising edges later. A done pulse clears `busy`, latches any cascade request and updates `irq_status` at the same edge. The bench therefore checks status and `busy` one edge after `done`, and checks the cascaded grant one edge after that. The `irq` output follows the status and the mask without extra delay, so it is checked in the same cycle as the status.

// File: rtl/dsched_pkg.sv
// Package: shared constants and the fixed cascade link tables.
// Assumes channel numbers are non-negative; -1 means "no link".
package dsched_pkg;
    localparam int CH_NUM = 10;

    // Successor requested after every single transfer of channel src.
    function automatic int xfer_link(input int src);
        case (src)
            0: return 1;
            1: return 2;
            2: return 0;
            3: return 4;
            5: return 6;
            6: return 7;
            7: return 5;
            8: return 9;
            default: return -1;
        endcase
    endfunction

    // Extra target requested when the count of channel src underflows.
    function automatic int uf_link(input int src);
        case (src)
            0: return 5;
            3: return 8;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/dsched_pend.sv
// Pending bank: one latched request bit per channel.
// Assumes grant_clr is one-hot or zero. done_acc is only high while a
// transfer of act_ch is outstanding.
module dsched_pend #(
    parameter int NCH  = 10,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ch_enable,
    input  logic [NCH-1:0]  casc_enable,
    input  logic [NCH-1:0]  ext_trig,
    input  logic            done_acc,
    input  logic            done_uf,
    input  logic [CH_W-1:0] act_ch,
    input  logic [NCH-1:0]  grant_clr,
    output logic [NCH-1:0]  pend_q
);
    import dsched_pkg::*;

    logic [NCH-1:0] casc_in;

    for (genvar t = 0; t < NCH; t++) begin : g_ch
        // Cascade hit for target t from the finishing channel.
        always_comb begin
            casc_in[t] = 1'b0;
            if (done_acc && casc_enable[t]) begin
                if (xfer_link(int'(act_ch)) == t)
                    casc_in[t] = 1'b1;
                if (done_uf && (uf_link(int'(act_ch)) == t))
                    casc_in[t] = 1'b1;
            end
        end

        // Hold until granted; new triggers re-set; disable drops the bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[t] <= 1'b0;
            else
                pend_q[t] <= ch_enable[t] &
                             ((pend_q[t] & ~grant_clr[t]) | ext_trig[t] | casc_in[t]);
        end
    end
endmodule

// File: rtl/dsched_arb.sv
// Fixed-priority picker: lowest index wins. Purely combinational.
// Assumes req may be any pattern; any_req is 0 when req is zero.
module dsched_arb #(
    parameter int NCH  = 10,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req,
    output logic            any_req,
    output logic [NCH-1:0]  win_oh,
    output logic [CH_W-1:0] win_idx
);
    logic [NCH:0] higher;

    assign higher[0] = 1'b0;
    for (genvar i = 0; i < NCH; i++) begin : g_chain
        assign higher[i+1] = higher[i] | req[i];
        assign win_oh[i]   = req[i] & ~higher[i];
    end
    assign any_req = higher[NCH];

    // Encode the one-hot winner into a channel number.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NCH; i++)
            if (win_oh[i])
                win_idx = win_idx | CH_W'(i);
    end
endmodule

// File: rtl/dsched_irq.sv
// Grouped interrupt: sticky per-channel underflow bits with write-1 clear.
// Assumes set_vec is one-hot or zero. A set beats a clear in the same cycle.
module dsched_irq #(
    parameter int NCH = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] set_vec,
    input  logic [NCH-1:0] clr_vec,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] status_q,
    output logic           irq
);
    // Sticky status update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= (status_q & ~clr_vec) | set_vec;
    end

    // Interrupt line from the unmasked bits.
    assign irq = |(status_q & mask);
endmodule

// File: rtl/dma_req_sched.sv
// Top: collects requests, grants one channel per transfer slot, waits
// for done, and drives the grouped underflow interrupt.
// Assumes done comes from the transfer engine for the channel last granted.
module dma_req_sched #(
    parameter int NCH  = dsched_pkg::CH_NUM,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  ch_enable,
    input  logic [NCH-1:0]  casc_enable,
    input  logic [NCH-1:0]  sw_trig,
    input  logic [NCH-1:0]  periph_req,
    input  logic            done,
    input  logic            done_uf,
    input  logic [NCH-1:0]  irq_mask,
    input  logic [NCH-1:0]  irq_clr,
    output logic            grant_valid,
    output logic [CH_W-1:0] grant_ch,
    output logic            busy,
    output logic [NCH-1:0]  irq_status,
    output logic            irq
);
    logic [NCH-1:0]  pend_q;
    logic [NCH-1:0]  win_oh;
    logic [CH_W-1:0] win_idx;
    logic            any_req;
    logic            busy_q;
    logic            grant_q;
    logic [CH_W-1:0] act_q;
    logic            done_acc;
    logic [NCH-1:0]  grant_clr;
    logic [NCH-1:0]  uf_set;

    // Done counts only while a transfer is outstanding.
    assign done_acc  = done & busy_q;
    // Clear the winner's pending bit in the slot it is granted.
    assign grant_clr = (!busy_q && any_req) ? win_oh : '0;
    // Underflow sets the status bit of the channel that finished.
    assign uf_set    = (done_acc && done_uf) ? (NCH'(1) << act_q) : '0;

    dsched_pend #(.NCH(NCH), .CH_W(CH_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_enable  (ch_enable),
        .casc_enable(casc_enable),
        .ext_trig   (sw_trig | periph_req),
        .done_acc   (done_acc),
        .done_uf    (done_uf),
        .act_ch     (act_q),
        .grant_clr  (grant_clr),
        .pend_q     (pend_q)
    );

    dsched_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
        .req    (pend_q),
        .any_req(any_req),
        .win_oh (win_oh),
        .win_idx(win_idx)
    );

    dsched_irq #(.NCH(NCH)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (uf_set),
        .clr_vec (irq_clr),
        .mask    (irq_mask),
        .status_q(irq_status),
        .irq     (irq)
    );

    // Slot control: grant when idle, hold busy until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            grant_q <= 1'b0;
            act_q   <= '0;
        end else begin
            grant_q <= 1'b0;
            if (done_acc) begin
                busy_q <= 1'b0;
            end else if (!busy_q && any_req) begin
                busy_q  <= 1'b1;
                grant_q <= 1'b1;
                act_q   <= win_idx;
            end
        end
    end

    assign grant_valid = grant_q;
    assign grant_ch    = act_q;
    assign busy        = busy_q;
endmodule

// File: rtl/dsched_chk.sv
// Checker: temporal properties of the scheduler, bound to the top.
// Assumes it sees the top's ports and its pending vector.
module dsched_chk #(
    parameter int NCH  = 10,
    parameter int CH_W = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  ch_enable,
    input logic [NCH-1:0]  pend_q,
    input logic            grant_valid,
    input logic [CH_W-1:0] grant_ch,
    input logic            busy,
    input logic            done,
    input logic            done_uf,
    input logic [NCH-1:0]  irq_clr,
    input logic [NCH-1:0]  irq_status
);
    logic [NCH-1:0] pend_prev;
    logic [NCH-1:0] low_mask;

    // Pending vector of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_prev <= '0;
        else        pend_prev <= pend_q;
    end

    // Channels that outrank the granted one.
    assign low_mask = (NCH'(1) << grant_ch) - NCH'(1);

    p_granted_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> pend_prev[grant_ch]);

    p_fixed_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((pend_prev & low_mask) == '0));

    p_no_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (busy && !$past(busy)));

    p_one_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid);

    p_disabled_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(ch_enable)) == '0);

    p_uf_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done && done_uf) |=> (irq_status != '0));

    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && done && irq_clr == '0) |=> ($stable(irq_status) && !busy));
endmodule

bind dma_req_sched dsched_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_enable  (ch_enable),
    .pend_q     (pend_q),
    .grant_valid(grant_valid),
    .grant_ch   (grant_ch),
    .busy       (busy),
    .done       (done),
    .done_uf    (done_uf),
    .irq_clr    (irq_clr),
    .irq_status (irq_status)
);

// File: tb/sim_dma_req_sched.sv
// Bench: vector table of trigger patterns, then directed tests.
module sim_dma_req_sched;
    localparam int NCH = 10;
    localparam int NV  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] ch_enable = '1;
    logic [NCH-1:0] casc_enable = '0;
    logic [NCH-1:0] sw_trig = '0;
    logic [NCH-1:0] periph_req = '0;
    logic           done = 1'b0;
    logic           done_uf = 1'b0;
    logic [NCH-1:0] irq_mask = '0;
    logic [NCH-1:0] irq_clr = '0;
    logic           grant_valid;
    logic [3:0]     grant_ch;
    logic           busy;
    logic [NCH-1:0] irq_status;
    logic           irq;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [NCH-1:0] VEC_TRIG [NV] = '{10'h001, 10'h200, 10'h210,
                                                 10'h00C, 10'h3FE, 10'h180};
    localparam int             VEC_EXP  [NV] = '{0, 9, 4, 2, 1, 7};
    localparam bit             VEC_PER  [NV] = '{0, 0, 1, 0, 1, 1};

    always #5 clk = ~clk;

    dma_req_sched u0 (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .casc_enable(casc_enable),
        .sw_trig(sw_trig), .periph_req(periph_req), .done(done), .done_uf(done_uf),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .grant_valid(grant_valid),
        .grant_ch(grant_ch), .busy(busy), .irq_status(irq_status), .irq(irq)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic trig_sw(input logic [NCH-1:0] m);
        sw_trig = m;
        tick();
        sw_trig = '0;
    endtask

    task automatic exp_grant(input string req, input int ch);
        tick();
        chk(req, int'(grant_valid), 1);
        chk(req, int'(grant_ch), ch);
    endtask

    task automatic finish_xfer(input logic uf);
        done = 1'b1;
        done_uf = uf;
        tick();
        done = 1'b0;
        done_uf = 1'b0;
    endtask

    task automatic drain();
        casc_enable = '0;
        repeat (24) begin
            if (busy) finish_xfer(1'b0);
            else tick();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        // R1: reset state, including a trigger held during reset
        @(negedge clk);
        sw_trig = 10'h001;
        repeat (3) tick();
        sw_trig = '0;
        chk("R1 grant", int'(grant_valid), 0);
        chk("R1 busy", int'(busy), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 grant after release", int'(grant_valid), 0);
        chk("R1 status", int'(irq_status), 0);
        chk("R1 irq", int'(irq), 0);

        // R2 / R3: vector table of trigger patterns
        for (int v = 0; v < NV; v++) begin
            if (VEC_PER[v]) periph_req = VEC_TRIG[v];
            else            sw_trig    = VEC_TRIG[v];
            tick();
            periph_req = '0;
            sw_trig = '0;
            exp_grant("R2 R3 vector", VEC_EXP[v]);
            chk("R2 busy with grant", int'(busy), 1);
            tick();
            chk("R2 grant one cycle", int'(grant_valid), 0);
            drain();
        end

        // R4: no grant while busy, regrant the edge after done
        trig_sw(10'h008);
        exp_grant("R4 first", 3);
        trig_sw(10'h002);
        tick();
        chk("R4 held while busy", int'(grant_valid), 0);
        finish_xfer(1'b0);
        chk("R4 no grant on done edge", int'(grant_valid), 0);
        chk("R4 busy falls", int'(busy), 0);
        exp_grant("R4 after done", 1);
        drain();

        // R5: disabled channel ignores a trigger and drops its pending bit
        ch_enable = 10'h3FB;
        trig_sw(10'h004);
        tick();
        chk("R5 disabled ignored", int'(grant_valid), 0);
        ch_enable = '1;
        tick();
        tick();
        chk("R5 not revived", int'(grant_valid), 0);
        trig_sw(10'h008);
        exp_grant("R5 setup", 3);
        trig_sw(10'h040);
        ch_enable = 10'h3BF;
        tick();
        ch_enable = '1;
        finish_xfer(1'b0);
        tick();
        chk("R5 pending dropped", int'(grant_valid), 0);
        drain();

        // R6: trigger at the grant edge re-latches
        trig_sw(10'h010);
        sw_trig = 10'h010;
        tick();
        sw_trig = '0;
        chk("R6 grant", int'(grant_ch), 4);
        finish_xfer(1'b0);
        exp_grant("R6 relatched", 4);
        drain();

        // R7: per-transfer cascades
        casc_enable = '1;
        trig_sw(10'h001);
        exp_grant("R7 start", 0);
        finish_xfer(1'b0);
        exp_grant("R7 0->1", 1);
        finish_xfer(1'b0);
        exp_grant("R7 1->2", 2);
        finish_xfer(1'b0);
        exp_grant("R7 2->0", 0);
        casc_enable = '0;
        finish_xfer(1'b0);
        tick();
        chk("R7 cascade off", int'(grant_valid), 0);
        casc_enable = '1;
        trig_sw(10'h008);
        exp_grant("R7 start 3", 3);
        finish_xfer(1'b0);
        exp_grant("R7 3->4", 4);
        finish_xfer(1'b0);
        tick();
        chk("R7 4 has no successor", int'(grant_valid), 0);
        trig_sw(10'h080);
        exp_grant("R7 start 7", 7);
        finish_xfer(1'b0);
        exp_grant("R7 7->5", 5);
        drain();
        casc_enable = '1;
        trig_sw(10'h100);
        exp_grant("R7 start 8", 8);
        finish_xfer(1'b0);
        exp_grant("R7 8->9", 9);
        finish_xfer(1'b0);
        tick();
        chk("R7 9 has no successor", int'(grant_valid), 0);
        casc_enable = 10'h3FD;
        trig_sw(10'h001);
        exp_grant("R7 gate start", 0);
        finish_xfer(1'b0);
        tick();
        chk("R7 gated target", int'(grant_valid), 0);
        drain();
        chk("R9 no underflow yet", int'(irq_status), 0);

        // R8: underflow links
        casc_enable = 10'h020;
        trig_sw(10'h001);
        exp_grant("R8 start 0", 0);
        finish_xfer(1'b1);
        exp_grant("R8 0->5", 5);
        drain();
        casc_enable = 10'h100;
        trig_sw(10'h008);
        exp_grant("R8 start 3", 3);
        finish_xfer(1'b1);
        exp_grant("R8 3->8", 8);
        drain();

        // R9 / R10: sticky status, mask and write-1 clear
        chk("R9 status bits 0 and 3", int'(irq_status), 9);
        chk("R10 masked off", int'(irq), 0);
        irq_mask = 10'h008;
        tick();
        chk("R10 unmasked", int'(irq), 1);
        irq_clr = 10'h008;
        tick();
        irq_clr = '0;
        chk("R9 w1c", int'(irq_status), 1);
        chk("R10 after clear", int'(irq), 0);
        trig_sw(10'h001);
        exp_grant("R9 setup", 0);
        irq_clr = 10'h001;
        finish_xfer(1'b1);
        irq_clr = '0;
        chk("R9 set beats clear", int'(irq_status), 1);
        irq_clr = 10'h001;
        tick();
        irq_clr = '0;
        chk("R9 cleared", int'(irq_status), 0);

        // R11: done while idle
        finish_xfer(1'b1);
        chk("R11 status unchanged", int'(irq_status), 0);
        chk("R11 still idle", int'(busy), 0);
        tick();
        chk("R11 no grant", int'(grant_valid), 0);

        report();
        $finish;
    end
endmodule